// File: doc/BRIEF.md
# Receive Input Crossbar and Channel Interleaver

This block sits between four 16-bit converter sample buses and a bank of up to four complex downconverter channels. A 32-bit control word chooses, for each channel, which converter feeds its I input and which feeds its Q input. A single flag can instead force every Q input to zero. The routed buses leave the block as outputs toward the channels.

The channels' I/Q results come back into the block. At each accepted sample strobe they are captured and sent out as a burst of 16-bit words on a valid/ready stream for the host link. A programmable channel count of 1, 2 or 4 sets how many words each burst holds.

The control word is taken in only when a strobe is accepted. Routing and burst length therefore change only at a sample-period boundary. A strobe that arrives while the previous burst is still draining is dropped, and a sticky overrun flag records it. An illegal channel count is treated as one channel and raises a sticky configuration-error flag.

Top module: `rx_xbar_interleave`

## Requirements
- R1: Control bits 2:0 give the active channel count N, with legal values 1, 2 and 4. Each accepted strobe produces a burst of exactly 2N words.
- R2: A channel-count field of 0, 3, 5, 6 or 7 behaves as N = 1, giving a 2-word burst. `cfg_err` is set when such a word is taken in and stays set until reset.
- R3: While the accepted control word has bit 3 set, every channel's routed Q bus is zero.
- R4: Channel k's I bus carries converter s, where s is the value of control bits (5+2k):(4+2k). Converter s sits at `adc_bus[16s+15:16s]`, and channel k's routed I is `route_i[16k+15:16k]`.
- R5: With bit 3 clear, channel k's Q bus carries converter s, where s is the value of control bits (13+2k):(12+2k). Channel k's routed Q is `route_q[16k+15:16k]`.
- R6: Control bits 31:20 have no effect on routing or burst length.
- R7: Within a burst, words follow the order ch0 I, ch0 Q, ch1 I, ch1 Q and so on. Channel k's result comes from `res_i`/`res_q` bits 16k+15:16k as sampled at the accepted strobe. `out_last` is high exactly on the final word.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R9: Changing `ctrl_word` between accepted strobes changes neither the routing nor the length of a burst.
- R10: A strobe that arrives while a burst still has words left (other than a final word being accepted in that cycle) is dropped. The burst in flight and the routing stay unchanged, and `ovr_flag` is set and stays set until reset.
- R11: A strobe that arrives in the cycle the final word of a burst is accepted starts the next burst with no gap, and no overrun is recorded.
- R12: After reset `out_valid`, `cfg_err` and `ovr_flag` are low, and every channel's I and Q bus carries converter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Sample-period strobe |
| ctrl_word | input | 32 | Routing and channel-count control |
| adc_bus | input | 64 | Four converter samples, converter k in bits 16k+15:16k |
| route_i | output | 64 | Routed I input for each channel |
| route_q | output | 64 | Routed Q input for each channel |
| res_i | input | 64 | Channel I results |
| res_q | input | 64 | Channel Q results |
| out_data | output | 16 | Serialized word |
| out_valid | output | 1 | Word valid |
| out_ready | input | 1 | Downstream ready |
| out_last | output | 1 | Final word of a burst |
| cfg_err | output | 1 | Sticky illegal channel-count flag |
| ovr_flag | output | 1 | Sticky dropped-strobe flag |

## Verification
The bench targets the boundary cases between bursts. A strobe coincides with the final word's handshake: a design with an off-by-one busy test would either raise a false overrun there or emit a stale word. A strobe arrives mid-burst while the output is stalled: a design that captured it anyway would corrupt the words in flight or switch the routing early. The bench also changes the control word between strobes, which exposes a design that follows the control word live and so mixes configurations within a burst. Finally, it drives illegal and reserved-bit control values, which would reveal a burst of the wrong length or a mis-decoded selector field.

// File: rtl/rxx_pkg.sv
// Shared definitions for the receive crossbar/interleaver.
// Assumes a fixed control-word layout of four channels and four converters.
package rxx_pkg;
    localparam int SAMP_W   = 16;
    localparam int N_CONV   = 4;
    localparam int N_CHAN   = 4;
    localparam int SEL_W    = $clog2(N_CONV);
    localparam int CTRL_W   = 32;
    localparam int NCH_LSB  = 0;
    localparam int ZERO_BIT = 3;
    localparam int ISEL_LSB = 4;
    localparam int QSEL_LSB = ISEL_LSB + N_CHAN * SEL_W;

    typedef struct packed {
        logic [2:0]                        nch;
        logic                              zero_q;
        logic [N_CHAN-1:0][SEL_W-1:0]      isel;
        logic [N_CHAN-1:0][SEL_W-1:0]      qsel;
    } rx_cfg_t;

    // True when the channel-count field holds a legal value.
    function automatic logic nch_legal(input logic [2:0] f);
        return (f == 3'd1) || (f == 3'd2) || (f == 3'd4);
    endfunction

    // Decode a control word into a configuration; illegal counts become 1.
    function automatic rx_cfg_t cfg_decode(input logic [CTRL_W-1:0] w);
        rx_cfg_t c;
        c.nch    = nch_legal(w[NCH_LSB +: 3]) ? w[NCH_LSB +: 3] : 3'd1;
        c.zero_q = w[ZERO_BIT];
        for (int k = 0; k < N_CHAN; k++) begin
            c.isel[k] = w[ISEL_LSB + k*SEL_W +: SEL_W];
            c.qsel[k] = w[QSEL_LSB + k*SEL_W +: SEL_W];
        end
        return c;
    endfunction
endpackage

// File: rtl/rxx_cfg_reg.sv
// Holds the active configuration. Loads only when the interleaver accepts
// a strobe, so routing and burst length change at period boundaries.
// Assumes the decoded word is presented in the same cycle as the load.
module rxx_cfg_reg
    import rxx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  rx_cfg_t nxt_cfg,
    input  logic    nxt_illegal,
    output rx_cfg_t cur_cfg,
    output logic    cfg_err
);
    // Configuration register: reset to one channel, all sources converter 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cfg        <= '0;
            cur_cfg.nch    <= 3'd1;
        end else if (load) begin
            cur_cfg <= nxt_cfg;
        end
    end

    // Sticky flag for an illegal channel count seen at a load.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cfg_err <= 1'b0;
        else if (load && nxt_illegal) cfg_err <= 1'b1;
    end
endmodule

// File: rtl/rxx_route.sv
// Per-channel source crossbar: picks a converter bus for each channel's
// I and Q inputs, with a global override that zeroes all Q inputs.
// Assumes the configuration is registered upstream (pure combinational).
module rxx_route
    import rxx_pkg::*;
#(
    parameter int SW = SAMP_W,
    parameter int NV = N_CONV,
    parameter int NC = N_CHAN
) (
    input  rx_cfg_t          cfg,
    input  logic [NV*SW-1:0] adc_bus,
    output logic [NC*SW-1:0] route_i,
    output logic [NC*SW-1:0] route_q
);
    for (genvar k = 0; k < NC; k++) begin : g_chan
        // Select this channel's I and Q sources.
        always_comb begin
            route_i[k*SW +: SW] = adc_bus[int'(cfg.isel[k])*SW +: SW];
            route_q[k*SW +: SW] = cfg.zero_q ? '0
                                             : adc_bus[int'(cfg.qsel[k])*SW +: SW];
        end
    end
endmodule

// File: rtl/rxx_interleave.sv
// Captures channel results on an accepted strobe and serializes them as
// 2N words (I then Q, ascending channel) on a valid/ready stream.
// A strobe is accepted when idle or when the final word leaves this cycle;
// otherwise it is dropped and a sticky overrun flag is set.
module rxx_interleave
    import rxx_pkg::*;
#(
    parameter int SW = SAMP_W,
    parameter int NC = N_CHAN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic [2:0]       nxt_nch,
    input  logic [NC*SW-1:0] res_i,
    input  logic [NC*SW-1:0] res_q,
    input  logic             out_ready,
    output logic [SW-1:0]    out_data,
    output logic             out_valid,
    output logic             out_last,
    output logic             accept,
    output logic             ovr_flag
);
    localparam int NW = 2 * NC;
    localparam int IW = $clog2(NW);

    logic [SW-1:0] wbuf [NW];
    logic [IW-1:0] idx;
    logic [IW-1:0] last_idx;
    logic          at_end;

    // Final-word and acceptance decisions.
    always_comb begin
        at_end   = out_valid && (idx == last_idx);
        accept   = smp_stb && (!out_valid || (out_ready && at_end));
        out_data = wbuf[idx];
        out_last = at_end;
    end

    // Word buffer: loaded with all channel results on an accepted strobe.
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int k = 0; k < NC; k++) begin
                wbuf[2*k]     <= res_i[k*SW +: SW];
                wbuf[2*k + 1] <= res_q[k*SW +: SW];
            end
        end
    end

    // Burst sequencing: index, length and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            idx       <= '0;
            last_idx  <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            idx       <= '0;
            last_idx  <= IW'(2 * int'(nxt_nch) - 1);
        end else if (out_valid && out_ready) begin
            if (at_end) out_valid <= 1'b0;
            else        idx       <= idx + 1'b1;
        end
    end

    // Sticky overrun flag for a dropped strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovr_flag <= 1'b0;
        else if (smp_stb && !accept) ovr_flag <= 1'b1;
    end
endmodule

// File: rtl/rx_xbar_interleave.sv
// Top of the receive crossbar and channel interleaver. Decodes the control
// word, holds the active configuration, routes converters to channels and
// serializes channel results. Assumes one clock domain and that channel
// results are valid in the strobe cycle.
module rx_xbar_interleave
    import rxx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_stb,
    input  logic [CTRL_W-1:0]        ctrl_word,
    input  logic [N_CONV*SAMP_W-1:0] adc_bus,
    output logic [N_CHAN*SAMP_W-1:0] route_i,
    output logic [N_CHAN*SAMP_W-1:0] route_q,
    input  logic [N_CHAN*SAMP_W-1:0] res_i,
    input  logic [N_CHAN*SAMP_W-1:0] res_q,
    output logic [SAMP_W-1:0]        out_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     out_last,
    output logic                     cfg_err,
    output logic                     ovr_flag
);
    rx_cfg_t nxt_cfg;
    rx_cfg_t cur_cfg;
    logic    nxt_illegal;
    logic    accept;

    // Decode the incoming control word.
    always_comb begin
        nxt_cfg     = cfg_decode(ctrl_word);
        nxt_illegal = !nch_legal(ctrl_word[NCH_LSB +: 3]);
    end

    rxx_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .nxt_cfg    (nxt_cfg),
        .nxt_illegal(nxt_illegal),
        .cur_cfg    (cur_cfg),
        .cfg_err    (cfg_err)
    );

    rxx_route #(.SW(SAMP_W), .NV(N_CONV), .NC(N_CHAN)) u_route (
        .cfg    (cur_cfg),
        .adc_bus(adc_bus),
        .route_i(route_i),
        .route_q(route_q)
    );

    rxx_interleave #(.SW(SAMP_W), .NC(N_CHAN)) u_ilv (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_stb  (smp_stb),
        .nxt_nch  (nxt_cfg.nch),
        .res_i    (res_i),
        .res_q    (res_q),
        .out_ready(out_ready),
        .out_data (out_data),
        .out_valid(out_valid),
        .out_last (out_last),
        .accept   (accept),
        .ovr_flag (ovr_flag)
    );
endmodule

// File: rtl/rx_xbar_interleave_chk.sv
// Property checker for rx_xbar_interleave, attached by bind below.
module rx_xbar_interleave_chk
    import rxx_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     smp_stb,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [SAMP_W-1:0]        out_data,
    input logic                     out_last,
    input logic                     cfg_err,
    input logic                     ovr_flag,
    input logic                     act_zero,
    input logic [N_CHAN*SAMP_W-1:0] route_q
);
    a_r3_zero_q: assert property (@(posedge clk) disable iff (!rst_n)
        act_zero |-> (route_q == '0));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |=> ovr_flag);

    a_r10_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> ($past(smp_stb) && $past(out_valid)));
endmodule

bind rx_xbar_interleave rx_xbar_interleave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last),
    .cfg_err  (cfg_err),
    .ovr_flag (ovr_flag),
    .act_zero (cur_cfg.zero_q),
    .route_q  (route_q)
);

// File: tb/rx_xbar_interleave_bench.sv
module rx_xbar_interleave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [63:0] adc_bus;
    logic [63:0] route_i, route_q;
    logic [63:0] res_i = '0, res_q = '0;
    logic [15:0] out_data;
    logic        out_valid, out_ready = 1'b0, out_last, cfg_err, ovr_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [15:0] exp_w [8];

    always #2.5 clk = ~clk;

    rx_xbar_interleave u_rx_xbar_interleave (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .ctrl_word(ctrl_word),
        .adc_bus(adc_bus), .route_i(route_i), .route_q(route_q),
        .res_i(res_i), .res_q(res_q), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
        .cfg_err(cfg_err), .ovr_flag(ovr_flag)
    );

    // Fixed, distinct converter samples.
    assign adc_bus = {16'hC333, 16'hC222, 16'hC111, 16'hC000};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [2:0] n, input logic z,
                                            input logic [7:0] is, input logic [7:0] qs);
        return {12'h000, qs, is, z, n};
    endfunction

    // Expected routing from the control-word fields.
    function automatic logic [63:0] exp_route(input logic [31:0] c, input bit q);
        logic [63:0] r;
        for (int k = 0; k < 4; k++) begin
            int s = q ? int'(c[12+2*k +: 2]) : int'(c[4+2*k +: 2]);
            r[16*k +: 16] = (q && c[3]) ? 16'h0000 : adc_bus[16*s +: 16];
        end
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; smp_stb = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_res(input logic [15:0] seed);
        for (int k = 0; k < 4; k++) begin
            res_i[16*k +: 16] = seed + 16'(2*k);
            res_q[16*k +: 16] = seed + 16'(2*k + 1);
            exp_w[2*k]   = seed + 16'(2*k);
            exp_w[2*k+1] = seed + 16'(2*k + 1);
        end
    endtask

    task automatic strobe(input logic [31:0] c);
        ctrl_word = c; smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic drain(input int n, input string tag);
        out_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            chk({tag, " valid"}, 64'(out_valid), 64'd1);
            chk({tag, " data"},  64'(out_data), 64'(exp_w[i]));
            chk({tag, " last"},  64'(out_last), 64'(i == n-1));
            @(negedge clk);
        end
        chk({tag, " idle after burst"}, 64'(out_valid), 64'd0);
    endtask

    // R12: reset state.
    task automatic t_reset();
        do_reset();
        chk("R12 valid", 64'(out_valid), 64'd0);
        chk("R12 cfg_err", 64'(cfg_err), 64'd0);
        chk("R12 ovr", 64'(ovr_flag), 64'd0);
        chk("R12 route_i", route_i, {4{16'hC000}});
        chk("R12 route_q", route_q, {4{16'hC000}});
    endtask

    // R4 R5 R3: crossbar selection and Q zeroing.
    task automatic t_route(input logic [31:0] c, input string tag);
        load_res(16'h1000);
        strobe(c);
        chk({tag, " route_i"}, route_i, exp_route(c, 1'b0));
        chk({tag, " route_q"}, route_q, exp_route(c, 1'b1));
        drain(2 * int'(c[2:0] == 3'd0 ? 3'd1 : c[2:0]), tag);
    endtask

    // R1 R7: burst length and word order for a channel count.
    task automatic t_burst(input logic [2:0] n, input logic [15:0] seed);
        load_res(seed);
        strobe(mk_ctrl(n, 1'b0, 8'hE4, 8'h1B));
        drain(2 * int'(n), $sformatf("R1 R7 n=%0d", n));
    endtask

    // R2: illegal counts give two words and a sticky error.
    task automatic t_illegal();
        do_reset();
        load_res(16'h3000);
        strobe(mk_ctrl(3'd3, 1'b0, 8'h00, 8'h00));
        chk("R2 cfg_err set", 64'(cfg_err), 64'd1);
        drain(2, "R2 n=3");
        load_res(16'h3100);
        strobe(mk_ctrl(3'd0, 1'b0, 8'h00, 8'h00));
        drain(2, "R2 n=0");
        load_res(16'h3200);
        strobe(mk_ctrl(3'd2, 1'b0, 8'h00, 8'h00));
        chk("R2 cfg_err sticky", 64'(cfg_err), 64'd1);
        drain(4, "R2 legal after");
    endtask

    // R8: stalled output holds its word.
    task automatic t_stall();
        do_reset();
        load_res(16'h4000);
        out_ready = 1'b0;
        strobe(mk_ctrl(3'd2, 1'b0, 8'h00, 8'h00));
        repeat (3) @(negedge clk);
        chk("R8 held valid", 64'(out_valid), 64'd1);
        chk("R8 held data", 64'(out_data), 64'(exp_w[0]));
        drain(4, "R8 after stall");
    endtask

    // R9: control changes between strobes do not apply.
    task automatic t_hold_cfg();
        logic [31:0] c0;
        do_reset();
        c0 = mk_ctrl(3'd1, 1'b0, 8'h1B, 8'hE4);
        load_res(16'h5000);
        out_ready = 1'b0;
        strobe(c0);
        ctrl_word = mk_ctrl(3'd4, 1'b1, 8'hFF, 8'hFF);
        @(negedge clk);
        chk("R9 route_i", route_i, exp_route(c0, 1'b0));
        chk("R9 route_q", route_q, exp_route(c0, 1'b1));
        drain(2, "R9 burst");
    endtask

    // R11: strobe on the final handshake starts the next burst.
    task automatic t_b2b();
        do_reset();
        load_res(16'h6000);
        out_ready = 1'b1;
        strobe(mk_ctrl(3'd1, 1'b0, 8'h00, 8'h00));
        @(negedge clk);
        chk("R11 final word", 64'(out_last), 64'd1);
        load_res(16'h6100);
        strobe(mk_ctrl(3'd2, 1'b0, 8'h00, 8'h00));
        chk("R11 no overrun", 64'(ovr_flag), 64'd0);
        drain(4, "R11 next burst");
    endtask

    // R10: mid-burst strobe is dropped.
    task automatic t_overrun();
        logic [31:0] c0;
        do_reset();
        c0 = mk_ctrl(3'd1, 1'b0, 8'h39, 8'hC6);
        load_res(16'h7000);
        out_ready = 1'b0;
        strobe(c0);
        res_i = {4{16'hDEAD}}; res_q = {4{16'hBEEF}};
        strobe(mk_ctrl(3'd4, 1'b1, 8'hFF, 8'h00));
        chk("R10 ovr set", 64'(ovr_flag), 64'd1);
        chk("R10 route kept", route_i, exp_route(c0, 1'b0));
        drain(2, "R10 burst intact");
        chk("R10 ovr sticky", 64'(ovr_flag), 64'd1);
    endtask

    // R6: reserved bits ignored.
    task automatic t_reserved();
        logic [31:0] c;
        do_reset();
        c = mk_ctrl(3'd2, 1'b0, 8'h9C, 8'h63);
        load_res(16'h8000);
        strobe(c | 32'hFFF0_0000);
        chk("R6 route_i", route_i, exp_route(c, 1'b0));
        chk("R6 route_q", route_q, exp_route(c, 1'b1));
        drain(4, "R6 burst");
    endtask

    initial begin
        t_reset();
        t_route(mk_ctrl(3'd1, 1'b0, 8'h1B, 8'h4E), "R4 R5 mix");
        t_route(mk_ctrl(3'd1, 1'b1, 8'hE4, 8'hFF), "R3 zero");
        t_burst(3'd1, 16'h2000);
        t_burst(3'd2, 16'h2100);
        t_burst(3'd4, 16'h2200);
        t_illegal();
        t_stall();
        t_hold_cfg();
        t_b2b();
        t_overrun();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule